// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is a single DMA channel that moves a chain of buffers. Software loads a fixed source start address and a pointer to the first descriptor in memory, then sets the channel enable. For each buffer the channel reads a four-word descriptor from memory. The words are destination address, control word A, control word B and next-descriptor pointer. The channel clears the done flag in the memory copy of control word A and copies the buffer one 32-bit word at a time. It then writes control word A back with the done flag set and the moved-word count in place. The source address goes back to its programmed start value for every buffer, so each buffer copies the same source region to a new destination.

After each buffer the channel raises a sticky buffer-complete interrupt. It then decides from the descriptor it just used whether the chain has ended. If it has, the channel raises a sticky transfer-complete interrupt and drops its enable. If not, it fetches the next descriptor from the pointer. Software can clear the enable at any time to abort. The channel then stops at the end of the memory write in progress, and a read that has already completed is still followed by its write.

Top module: `ll_dma_channel`

## Requirements
- R1: After reset, `ch_en`, `irq_buf_done`, `irq_xfer_done` and `mem_req` are all low.
- R2: Writing 1 to bit 0 of the control register (select 2) while the channel is idle starts the channel. The first access is a read at the descriptor pointer (select 1). Each descriptor is read as four words at pointer+0, +4, +8, +12, holding destination, control A, control B and next pointer, and no other descriptor word is read.
- R3: Before the first data beat of a buffer, the channel writes control word A to descriptor+4 with bit 31 (done) cleared and bits 30:0 unchanged.
- R4: A buffer moves the number of words given in control word A bits 15:0. Each beat reads the source address and writes the word to the destination address, and both addresses advance by 4. A size of 0 moves nothing. A request is held with a stable, word-aligned address until acknowledged.
- R5: At the end of a buffer, the channel writes descriptor+4 with bit 31 set, bits 15:0 holding the moved-word count and bits 30:16 unchanged. It writes no other descriptor word, and it writes each control word A exactly twice.
- R6: Every buffer reads its source from the programmed source address (select 0), never from a descriptor.
- R7: The chain ends after the current buffer when control word B has bit 31 (source reload) and bit 30 (destination list) both clear, or when the next pointer is 0. In that case the channel sets `irq_xfer_done`, clears `ch_en` and fetches nothing more. Otherwise it fetches the descriptor at the next pointer.
- R8: `irq_buf_done` is set at the end of every buffer and stays set until cleared.
- R9: Writing 0 to bit 0 of the control register aborts the chain. No request follows the next acknowledged write, and no write-back or transfer-complete interrupt follows for an unfinished buffer.
- R10: Writes to the source and pointer registers while `ch_en` is high are ignored.
- R11: `irq_clr[0]` clears `irq_buf_done` and `irq_clr[1]` clears `irq_xfer_done`, each independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 first-descriptor pointer, 2 control |
| cfg_wdata | input | 32 | Register write data |
| ch_en | output | 1 | Channel enable status |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| irq_clr | input | 2 | Bit 0 clears buffer-complete, bit 1 clears transfer-complete |
| irq_buf_done | output | 1 | Sticky buffer-complete interrupt |
| irq_xfer_done | output | 1 | Sticky transfer-complete interrupt |

## Verification
A wrong descriptor index or pointer shows at the memory port within one access. The wrong word lands in a destination or control slot, or the descriptor read count differs from four per buffer. A bad beat counter or last-buffer decision shows at the end of the chain. The write-back count differs, a trap descriptor placed after the last one gets fetched and its destination is overwritten, or the interrupts and enable end in the wrong state. A lost source reload corrupts the very next buffer's destination data.

// File: rtl/ll_dma_pkg.sv
// Shared constants and state type for the linked-list DMA channel.
// Assumes 32-bit descriptor words and a word-addressed beat size of 4 bytes.
package ll_dma_pkg;
    localparam int DATA_W           = 32;
    localparam int CTLA_DONE_BIT    = 31;
    localparam int CTLB_SRC_RLD_BIT = 31;
    localparam int CTLB_DST_LL_BIT  = 30;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_PTR  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CLR,
        ST_RD,
        ST_WR,
        ST_WB
    } seq_state_t;
endpackage

// File: rtl/ll_dma_regs.sv
// Programming registers: source start, first descriptor pointer, enable.
// Assumes software writes one register per cycle; address writes are
// accepted only while the channel is disabled. Addresses are forced aligned.
module ll_dma_regs
    import ll_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              hw_clr,
    output logic [ADDR_W-1:0] src_init,
    output logic [ADDR_W-1:0] ptr_init,
    output logic              ch_en,
    output logic              start
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0] wr_addr;

    // Word-aligned form of the write data for the address registers.
    assign wr_addr = wr_data[ADDR_W-1:0] & ALIGN_MASK;

    // Start request: enable written high while fully idle.
    assign start = wr_en && (wr_sel == SEL_CTRL) && wr_data[0] && !ch_en && !busy;

    // Register update; hardware clear of the enable wins over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_init <= '0;
            ptr_init <= '0;
            ch_en    <= 1'b0;
        end else begin
            if (wr_en && !ch_en && (wr_sel == SEL_SRC)) src_init <= wr_addr;
            if (wr_en && !ch_en && (wr_sel == SEL_PTR)) ptr_init <= wr_addr;
            if (start) ch_en <= 1'b1;
            else if (wr_en && (wr_sel == SEL_CTRL) && !wr_data[0]) ch_en <= 1'b0;
            if (hw_clr) ch_en <= 1'b0;
        end
    end

    p_src_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en |=> ($stable(src_init) && $stable(ptr_init)));
endmodule

// File: rtl/ll_dma_last_det.sv
// Last-buffer decision from the descriptor in use.
// Assumes the flags and next pointer are those fetched for the current buffer.
module ll_dma_last_det #(
    parameter int ADDR_W = 32
) (
    input  logic              src_rld,
    input  logic              dst_ll,
    input  logic [ADDR_W-1:0] next_ptr,
    output logic              is_last
);
    // Chain ends when both list modes are off or no successor exists.
    always_comb begin
        is_last = (!src_rld && !dst_ll) || (next_ptr == '0);
    end
endmodule

// File: rtl/ll_dma_irq.sv
// Sticky interrupt flags for buffer and transfer completion.
// Assumes set pulses last one cycle; a set in the same cycle beats a clear.
module ll_dma_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       buf_set,
    input  logic       xfer_set,
    input  logic [1:0] clr,
    output logic       irq_buf,
    output logic       irq_xfer
);
    // Hold each flag until its own clear bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_buf  <= 1'b0;
            irq_xfer <= 1'b0;
        end else begin
            if (buf_set)     irq_buf <= 1'b1;
            else if (clr[0]) irq_buf <= 1'b0;
            if (xfer_set)    irq_xfer <= 1'b1;
            else if (clr[1]) irq_xfer <= 1'b0;
        end
    end

    p_buf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_buf && !clr[0]) |=> irq_buf);
    p_xfer_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[1] && !xfer_set) |=> !irq_xfer);
endmodule

// File: rtl/ll_dma_seq.sv
// Channel sequencer: descriptor fetch, done-flag clear, data beats,
// control write-back and source reload. One memory access at a time;
// the request stays up until acknowledged. Abort is sampled at each
// acknowledged access; a completed read is always followed by its write.
module ll_dma_seq
    import ll_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ch_en,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] ptr_init,
    input  logic              is_last,
    output logic              src_rld,
    output logic              dst_ll,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              busy,
    output logic              buf_done,
    output logic              xfer_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(4);
    localparam logic [1:0]        LAST_IDX   = 2'd3;

    seq_state_t        state;
    logic [1:0]        idx;
    logic [ADDR_W-1:0] desc_ptr;
    logic [ADDR_W-1:0] cur_desc;
    logic [ADDR_W-1:0] src_cur;
    logic [ADDR_W-1:0] dst_cur;
    logic [DATA_W-1:0] ctla;
    logic [1:0]        ctlb_flags;
    logic [CNT_W-1:0]  beat_cnt;
    logic [DATA_W-1:0] data_buf;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  size;
    logic [DATA_W-1:0] wb_word;
    logic [DATA_W-1:0] clr_word;
    logic              final_beat;

    assign rd_addr    = mem_rdata[ADDR_W-1:0] & ALIGN_MASK;
    assign size       = ctla[CNT_W-1:0];
    assign final_beat = (beat_cnt + 1'b1) == size;
    assign src_rld    = ctlb_flags[1];
    assign dst_ll     = ctlb_flags[0];
    assign next_ptr   = desc_ptr;
    assign busy       = (state != ST_IDLE);
    assign buf_done   = (state == ST_WB) && mem_ack;
    assign xfer_done  = buf_done && ch_en && is_last;

    // Status words for the start-of-buffer clear and end-of-buffer update.
    always_comb begin
        clr_word = ctla;
        clr_word[CTLA_DONE_BIT] = 1'b0;
        wb_word = ctla;
        wb_word[CNT_W-1:0] = beat_cnt;
        wb_word[CTLA_DONE_BIT] = 1'b1;
    end

    // Memory port drive from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + ADDR_W'({idx, 2'b00});
            end
            ST_CLR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc + WORD_STEP;
                mem_wdata = clr_word;
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_cur;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_cur;
                mem_wdata = data_buf;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc + WORD_STEP;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    // Sequencer state and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            desc_ptr   <= '0;
            cur_desc   <= '0;
            src_cur    <= '0;
            dst_cur    <= '0;
            ctla       <= '0;
            ctlb_flags <= '0;
            beat_cnt   <= '0;
            data_buf   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        src_cur  <= src_init;
                        desc_ptr <= ptr_init;
                        idx      <= '0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        case (idx)
                            2'd0: dst_cur <= rd_addr;
                            2'd1: ctla <= mem_rdata;
                            2'd2: ctlb_flags <= {mem_rdata[CTLB_SRC_RLD_BIT],
                                                 mem_rdata[CTLB_DST_LL_BIT]};
                            default: begin
                                cur_desc <= desc_ptr;
                                desc_ptr <= rd_addr;
                            end
                        endcase
                        idx <= idx + 1'b1;
                        if (!ch_en) state <= ST_IDLE;
                        else if (idx == LAST_IDX) state <= ST_CLR;
                    end
                end
                ST_CLR: begin
                    if (mem_ack) begin
                        beat_cnt <= '0;
                        if (!ch_en) state <= ST_IDLE;
                        else if (size == '0) state <= ST_WB;
                        else state <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        data_buf <= mem_rdata;
                        state    <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        src_cur  <= src_cur + WORD_STEP;
                        dst_cur  <= dst_cur + WORD_STEP;
                        beat_cnt <= beat_cnt + 1'b1;
                        if (!ch_en) state <= ST_IDLE;
                        else if (final_beat) state <= ST_WB;
                        else state <= ST_RD;
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        src_cur <= src_init;
                        idx     <= '0;
                        if (!ch_en || is_last) state <= ST_IDLE;
                        else state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    p_addr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_we && !ch_en) |=> !mem_req);
endmodule

// File: rtl/ll_dma_channel.sv
// Top of the linked-list DMA channel: register block, sequencer,
// last-buffer detector and interrupt flags. Assumes a single memory
// slave that acknowledges each held request exactly once.
module ll_dma_channel
    import ll_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              ch_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [1:0]        irq_clr,
    output logic              irq_buf_done,
    output logic              irq_xfer_done
);
    logic [ADDR_W-1:0] src_init;
    logic [ADDR_W-1:0] ptr_init;
    logic [ADDR_W-1:0] next_ptr;
    logic              start;
    logic              busy;
    logic              src_rld;
    logic              dst_ll;
    logic              is_last;
    logic              buf_done;
    logic              xfer_done;

    ll_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .busy     (busy),
        .hw_clr   (xfer_done),
        .src_init (src_init),
        .ptr_init (ptr_init),
        .ch_en    (ch_en),
        .start    (start)
    );

    ll_dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ch_en     (ch_en),
        .src_init  (src_init),
        .ptr_init  (ptr_init),
        .is_last   (is_last),
        .src_rld   (src_rld),
        .dst_ll    (dst_ll),
        .next_ptr  (next_ptr),
        .busy      (busy),
        .buf_done  (buf_done),
        .xfer_done (xfer_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    ll_dma_last_det #(.ADDR_W(ADDR_W)) u_last (
        .src_rld  (src_rld),
        .dst_ll   (dst_ll),
        .next_ptr (next_ptr),
        .is_last  (is_last)
    );

    ll_dma_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_set  (buf_done),
        .xfer_set (xfer_done),
        .clr      (irq_clr),
        .irq_buf  (irq_buf_done),
        .irq_xfer (irq_xfer_done)
    );

    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mem_req && !mem_we && (mem_addr == $past(ptr_init))));
    p_xfer_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (irq_xfer_done && !ch_en));
endmodule

// File: tb/ll_dma_channel_bench.sv
// Self-checking bench: memory model with random acknowledge delay,
// directed and seeded random descriptor chains, abort and register tests.
module ll_dma_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        ch_en;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  irq_clr = 2'b00;
    logic        irq_buf_done;
    logic        irq_xfer_done;

    always #5 clk = ~clk;

    ll_dma_channel u_ll_dma_channel (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ch_en(ch_en), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_clr(irq_clr),
        .irq_buf_done(irq_buf_done), .irq_xfer_done(irq_xfer_done)
    );

    logic [31:0] mem [256];
    logic [31:0] wlog_addr [1024];
    logic [31:0] wlog_data [1024];
    int          n_wlog = 0;
    int          desc_reads = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    int          sz [8];
    logic [31:0] d_dst [8];
    logic [31:0] d_ctla [8];
    logic [31:0] d_ctlb [8];
    logic [31:0] d_next [8];
    logic [31:0] src_copy [16];

    // Memory slave: one acknowledge per request after 0..2 idle cycles.
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && rst_n) begin
                if (wait_cnt == 0) begin
                    if (mem_we) begin
                        mem[mem_addr[9:2]] = mem_wdata;
                        if (n_wlog < 1024) begin
                            wlog_addr[n_wlog] = mem_addr;
                            wlog_data[n_wlog] = mem_wdata;
                        end
                        n_wlog++;
                    end else begin
                        mem_rdata = mem[mem_addr[9:2]];
                        if (mem_addr >= 32'h100 && mem_addr < 32'h200) desc_reads++;
                    end
                    mem_ack = 1'b1;
                    wait_cnt = $urandom % 3;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_sel = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] sentinel(input int w);
        return 32'hDEAD_0000 | 32'(w);
    endfunction

    function automatic logic [31:0] expect_wb(input int k);
        return {1'b1, d_ctla[k][30:16], 16'(sz[k])};
    endfunction

    // Lay out n descriptors plus a trap descriptor after the last one.
    task automatic build_chain(input int n, input int mode);
        for (int w = 128; w < 256; w++) mem[w] = sentinel(w);
        for (int j = 0; j < 16; j++) begin
            src_copy[j] = $urandom;
            mem[16 + j] = src_copy[j];
        end
        for (int k = 0; k < 8; k++) begin
            d_dst[k]  = 32'h200 + 32'(k) * 32'h40;
            d_ctla[k] = {1'b1, 15'($urandom), 16'(sz[k])};
            d_ctlb[k] = {2'(1 + $urandom % 3), 30'($urandom)};
            d_next[k] = 32'h100 + 32'(k + 1) * 32'h10;
            if (k == n - 1) begin
                if (mode == 0) d_next[k] = 32'h0;
                else d_ctlb[k] = {2'b00, 30'($urandom)};
            end
            if (k == n) begin
                d_ctla[k] = {1'b1, 15'd0, 16'd4};
                d_ctlb[k] = 32'hC000_0000;
                d_next[k] = 32'h0;
            end
            mem[64 + k * 4 + 0] = d_dst[k];
            mem[64 + k * 4 + 1] = d_ctla[k];
            mem[64 + k * 4 + 2] = d_ctlb[k];
            mem[64 + k * 4 + 3] = d_next[k];
        end
    endtask

    task automatic verify_chain(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            int first_seen;
            int wr_cnt;
            logic [31:0] ca;
            ca = 32'h104 + 32'(k) * 32'h10;
            chk("R5 writeback word", mem[64 + k * 4 + 1], expect_wb(k));
            chk("R5 dst slot untouched", mem[64 + k * 4], d_dst[k]);
            chk("R5 ctlb slot untouched", mem[64 + k * 4 + 2], d_ctlb[k]);
            chk("R5 next slot untouched", mem[64 + k * 4 + 3], d_next[k]);
            first_seen = 0;
            wr_cnt = 0;
            for (int e = 0; e < n_wlog && e < 1024; e++) begin
                if (wlog_addr[e] == ca) begin
                    if (first_seen == 0)
                        chk("R3 done cleared at start", wlog_data[e], d_ctla[k] & 32'h7FFF_FFFF);
                    first_seen = 1;
                    wr_cnt++;
                end
            end
            chk("R5 two control writes", 32'(wr_cnt), 32'd2);
            for (int j = 0; j < sz[k]; j++)
                chk("R4 R6 R10 beat data", mem[128 + k * 16 + j], src_copy[j]);
            chk("R4 no extra beat", mem[128 + k * 16 + sz[k]], sentinel(128 + k * 16 + sz[k]));
        end
        if (mode == 1)
            chk("R7 trap not fetched", mem[128 + n * 16], sentinel(128 + n * 16));
        chk("R2 R7 descriptor reads", 32'(desc_reads), 32'(4 * n));
        chk("R8 buffer irq", {31'd0, irq_buf_done}, 32'd1);
        chk("R7 transfer irq", {31'd0, irq_xfer_done}, 32'd1);
        chk("R7 enable cleared", {31'd0, ch_en}, 32'd0);
    endtask

    task automatic clear_irqs();
        @(negedge clk); irq_clr = 2'b01;
        @(negedge clk); irq_clr = 2'b00;
        chk("R11 buf cleared", {31'd0, irq_buf_done}, 32'd0);
        chk("R11 xfer kept", {31'd0, irq_xfer_done}, 32'd1);
        @(negedge clk); irq_clr = 2'b10;
        @(negedge clk); irq_clr = 2'b00;
        chk("R11 xfer cleared", {31'd0, irq_xfer_done}, 32'd0);
    endtask

    task automatic run_chain(input int n, input int mode, input bit scribble);
        int t;
        n_wlog = 0;
        desc_reads = 0;
        build_chain(n, mode);
        cfg_write(2'd0, 32'h40);
        cfg_write(2'd1, 32'h100);
        cfg_write(2'd2, 32'h1);
        if (scribble) begin
            cfg_write(2'd0, 32'h0C0);
            cfg_write(2'd1, 32'h170);
        end
        t = 0;
        while (ch_en && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk("R7 chain finished", 32'(t < 4000), 32'd1);
        repeat (3) @(negedge clk);
        verify_chain(n, mode);
        clear_irqs();
    endtask

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int w = 0; w < 256; w++) mem[w] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset enable", {31'd0, ch_en}, 32'd0);
        chk("R1 reset buf irq", {31'd0, irq_buf_done}, 32'd0);
        chk("R1 reset xfer irq", {31'd0, irq_xfer_done}, 32'd0);
        chk("R1 reset request", {31'd0, mem_req}, 32'd0);

        // Directed: end on zero pointer, register writes while running.
        sz[0] = 2; sz[1] = 1; sz[2] = 3;
        run_chain(3, 0, 1'b1);
        // Directed: end on control word B flags, trap after it.
        sz[0] = 4; sz[1] = 2;
        run_chain(2, 1, 1'b0);
        // Directed: zero-size buffer in the middle.
        sz[0] = 3; sz[1] = 0; sz[2] = 2;
        run_chain(3, 0, 1'b0);
        // Directed: single one-word buffer.
        sz[0] = 1;
        run_chain(1, 1, 1'b0);
        // Seeded random chains.
        for (int it = 0; it < 8; it++) begin
            int n;
            n = 1 + $urandom % 6;
            for (int k = 0; k < 8; k++) sz[k] = $urandom % 9;
            run_chain(n, $urandom % 2, it[0]);
        end

        // Abort in the middle of the first buffer.
        begin
            int t;
            int saved;
            n_wlog = 0;
            desc_reads = 0;
            sz[0] = 8; sz[1] = 8; sz[2] = 8;
            build_chain(3, 0);
            cfg_write(2'd0, 32'h40);
            cfg_write(2'd1, 32'h100);
            cfg_write(2'd2, 32'h1);
            t = 0;
            while (n_wlog < 4 && t < 2000) begin
                @(negedge clk);
                t++;
            end
            cfg_write(2'd2, 32'h0);
            repeat (12) @(negedge clk);
            chk("R9 request stopped", {31'd0, mem_req}, 32'd0);
            saved = n_wlog;
            repeat (30) @(negedge clk);
            chk("R9 no further writes", 32'(n_wlog), 32'(saved));
            chk("R9 no transfer irq", {31'd0, irq_xfer_done}, 32'd0);
            chk("R9 no buffer irq", {31'd0, irq_buf_done}, 32'd0);
            chk("R9 enable low", {31'd0, ch_en}, 32'd0);
            chk("R9 done stays clear", {31'd0, mem[65][31]}, 32'd0);
        end
        // Restart after abort.
        sz[0] = 2; sz[1] = 5;
        run_chain(2, 0, 1'b0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule